// File: doc/BRIEF.md
# Write-Leveling Training Sequencer

This block runs one write-leveling pass for a chosen DIMM on a DDR3 channel. It quiets the channel first: it holds auto-refresh off and sets the ZQ short-calibration interval to zero. It then asks an external mode-register sequencer to put the ranks into leveling mode and waits a fixed settle time. Next it raises the leveling ODT, lets it settle, and loads a seed delay into all byte lanes. After that it holds the phy's training enable high for a fixed number of memory clocks.

When training ends, the block reads the per-lane results and applies a gross-delay rounding rule to each lane. It writes the corrected values out as write-DQS delays. It then lowers the ODT, waits again, and asks the mode-register sequencer to return the ranks to mission mode. Finally it restores refresh and the normal ZQ interval and pulses done. The delay search inside the phy is not part of this block. The phy delivers its per-lane results on an input bus that the block samples once training has ended.

Top module: `wlvl_seq`

## Requirements
- R1: After reset, done, train_en, odt_lvl_en, prep_req, seed_wr and wdqs_wr are 0, refresh_off is 0, zq_interval is 2 and wdqs_bus is 0.
- R2: From the cycle after an accepted start until done, refresh_off is 1 and zq_interval is 0. This holds during the first prep request and during every training cycle.
- R3: The first prep request carries prep_level=1 and tgt_dimm equal to the dimm_sel_in sampled at start. After prep_ack, odt_lvl_en stays 0 for exactly MRS_WAIT (40) cycles and then rises.
- R4: odt_lvl_en is high for exactly ODT_WAIT (10) cycles before the single seed_wr pulse, and it is still high during that pulse.
- R5: The seed sampled at start depends on dimm_kind: 2'b01 (registered) gives 0x41, 2'b10 (small-outline) gives 0x12, and 2'b00 or 2'b11 give 0x1A. The same seed goes to every lane. Lane i occupies seed_bus[8i+7:8i]. Input changes after start have no effect on the run.
- R6: When seed_ovr_en is 1 at start, lane i's seed is seed_ovr[8i+7:8i] instead of the default.
- R7: train_en is high for exactly TRAIN_WAIT (200) consecutive cycles. It rises the cycle after seed_wr, and ODT is high the whole time.
- R8: res_bus is sampled in the cycle after train_en falls. A lane whose seed gross field (bits 7:5) is 0 and whose result gross field is 3 is written as 0x00.
- R9: Every other lane is written unchanged. wdqs_wr is a one-cycle pulse, wdqs_bus changes only together with wdqs_wr, and it then holds its value.
- R10: After wdqs_wr, odt_lvl_en is 0 and exactly ODT_WAIT cycles pass before a prep request with prep_level=0. After its ack, done pulses for one cycle with refresh_off=0, zq_interval=2 and ODT low.
- R11: A start pulse while a pass is in progress is ignored. Each accepted start produces exactly one seed write and one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (accepted when idle) |
| dimm_sel_in | input | DIMM_W | DIMM to train |
| dimm_kind | input | 2 | 0 unbuffered, 1 registered, 2 small-outline, 3 other |
| seed_ovr_en | input | 1 | Use per-lane seed overrides |
| seed_ovr | input | LANES*DW | Per-lane override seeds |
| prep_ack | input | 1 | Mode-register sequencer finished a prep request |
| res_bus | input | LANES*DW | Per-lane phy training results |
| done | output | 1 | One-cycle pass-complete pulse |
| refresh_off | output | 1 | Auto-refresh suppressed |
| zq_interval | output | 2 | ZQ short-calibration interval code |
| tgt_dimm | output | DIMM_W | Selected target DIMM |
| prep_req | output | 1 | One-cycle request to the mode-register sequencer |
| prep_level | output | 1 | 1 = leveling mode, 0 = mission mode |
| odt_lvl_en | output | 1 | Leveling ODT enable to the phy |
| seed_wr | output | 1 | Seed load strobe |
| seed_bus | output | LANES*DW | Per-lane seed delays |
| train_en | output | 1 | Phy training enable |
| wdqs_wr | output | 1 | Write-DQS delay load strobe |
| wdqs_bus | output | LANES*DW | Final per-lane write-DQS delays (held) |

## Verification
The block uses one down-counter for all of its waits. A wrong load value or a wrong state order therefore shows up at the ports as a settle window that is one or more cycles too long or too short. The bench measures every window between edges of prep_ack, odt_lvl_en, seed_wr, train_en, wdqs_wr and prep_req, so such an error is caught within the pass where it happens. A fault in the seed or in the rounding logic appears on seed_bus or wdqs_bus at the strobe of that same pass.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

    typedef enum logic [1:0] {
        KIND_UNBUF = 2'd0,
        KIND_REG   = 2'd1,
        KIND_SMALL = 2'd2,
        KIND_OTHER = 2'd3
    } dimm_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_QUIESCE,
        ST_PREP_LV,
        ST_ACK_LV,
        ST_MRS_SETTLE,
        ST_ODT_ON,
        ST_LOAD_SEED,
        ST_TRAIN,
        ST_CAPTURE,
        ST_COMMIT,
        ST_ODT_OFF,
        ST_PREP_MS,
        ST_ACK_MS,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic refresh_off;
        logic odt;
        logic train;
        logic seed_wr;
        logic wdqs_wr;
        logic prep_req;
        logic prep_level;
        logic done;
    } ctl_t;

    localparam logic [7:0] SEED_REG   = 8'h41;
    localparam logic [7:0] SEED_SMALL = 8'h12;
    localparam logic [7:0] SEED_UNBUF = 8'h1A;
    localparam logic [1:0] ZQ_OFF     = 2'd0;
    localparam logic [1:0] ZQ_NORMAL  = 2'd2;

    function automatic logic [7:0] default_seed(input dimm_kind_e k);
        case (k)
            KIND_REG:   return SEED_REG;
            KIND_SMALL: return SEED_SMALL;
            default:    return SEED_UNBUF;
        endcase
    endfunction

    function automatic ctl_t decode_ctl(input seq_state_e s);
        ctl_t c;
        c             = '0;
        c.refresh_off = (s != ST_IDLE) && (s != ST_FINISH);
        c.odt         = (s == ST_ODT_ON) || (s == ST_LOAD_SEED) || (s == ST_TRAIN) ||
                        (s == ST_CAPTURE) || (s == ST_COMMIT);
        c.train       = (s == ST_TRAIN);
        c.seed_wr     = (s == ST_LOAD_SEED);
        c.wdqs_wr     = (s == ST_COMMIT);
        c.prep_req    = (s == ST_PREP_LV) || (s == ST_PREP_MS);
        c.prep_level  = (s == ST_PREP_LV) || (s == ST_ACK_LV);
        c.done        = (s == ST_FINISH);
        return c;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wlvl_wait_cnt.sv
module wlvl_wait_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/wlvl_seed_pick.sv
module wlvl_seed_pick
    import wlvl_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 8
) (
    input  logic [1:0]          kind,
    input  logic                ovr_en,
    input  logic [LANES*DW-1:0] ovr,
    output logic [LANES*DW-1:0] seeds
);
    logic [DW-1:0] dflt;

    assign dflt = DW'(default_seed(dimm_kind_e'(kind)));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign seeds[l*DW +: DW] = ovr_en ? ovr[l*DW +: DW] : dflt;
    end
endmodule

// File: rtl/wlvl_lane_fix.sv
module wlvl_lane_fix #(
    parameter int DW        = 8,
    parameter int GROSS_LSB = 5
) (
    input  logic [DW-1:0] seed,
    input  logic [DW-1:0] result,
    output logic [DW-1:0] fixed
);
    localparam int GW = DW - GROSS_LSB;

    logic [GW-1:0] seed_gross;
    logic [GW-1:0] res_gross;

    assign seed_gross = seed[DW-1:GROSS_LSB];
    assign res_gross  = result[DW-1:GROSS_LSB];
    assign fixed      = ((seed_gross == '0) && (res_gross == GW'(3))) ? '0 : result;
endmodule

// File: rtl/wlvl_seq.sv
module wlvl_seq
    import wlvl_pkg::*;
#(
    parameter int LANES      = 8,
    parameter int DW         = 8,
    parameter int DIMM_W     = 2,
    parameter int MRS_WAIT   = 40,
    parameter int ODT_WAIT   = 10,
    parameter int TRAIN_WAIT = 200,
    parameter int GROSS_LSB  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [DIMM_W-1:0]   dimm_sel_in,
    input  logic [1:0]          dimm_kind,
    input  logic                seed_ovr_en,
    input  logic [LANES*DW-1:0] seed_ovr,
    input  logic                prep_ack,
    input  logic [LANES*DW-1:0] res_bus,
    output logic                done,
    output logic                refresh_off,
    output logic [1:0]          zq_interval,
    output logic [DIMM_W-1:0]   tgt_dimm,
    output logic                prep_req,
    output logic                prep_level,
    output logic                odt_lvl_en,
    output logic                seed_wr,
    output logic [LANES*DW-1:0] seed_bus,
    output logic                train_en,
    output logic                wdqs_wr,
    output logic [LANES*DW-1:0] wdqs_bus
);
    localparam int BUS_W    = LANES * DW;
    localparam int MAX_WAIT = max3(MRS_WAIT, ODT_WAIT, TRAIN_WAIT);
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    seq_state_e        state_q, state_d;
    ctl_t              ctl;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_done;
    logic [BUS_W-1:0]  seed_pick_bus;
    logic [BUS_W-1:0]  fixed_bus;
    logic [BUS_W-1:0]  seed_q;
    logic [BUS_W-1:0]  wdqs_q;
    logic [DIMM_W-1:0] tgt_q;

    wlvl_seed_pick #(.LANES(LANES), .DW(DW)) u_seed_pick (
        .kind   (dimm_kind),
        .ovr_en (seed_ovr_en),
        .ovr    (seed_ovr),
        .seeds  (seed_pick_bus)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_fix
        wlvl_lane_fix #(.DW(DW), .GROSS_LSB(GROSS_LSB)) u_fix (
            .seed   (seed_q[l*DW +: DW]),
            .result (res_bus[l*DW +: DW]),
            .fixed  (fixed_bus[l*DW +: DW])
        );
    end

    wlvl_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_done)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:       if (start) state_d = ST_QUIESCE;
            ST_QUIESCE:    state_d = ST_PREP_LV;
            ST_PREP_LV:    state_d = ST_ACK_LV;
            ST_ACK_LV:     if (prep_ack) state_d = ST_MRS_SETTLE;
            ST_MRS_SETTLE: if (cnt_done) state_d = ST_ODT_ON;
            ST_ODT_ON:     if (cnt_done) state_d = ST_LOAD_SEED;
            ST_LOAD_SEED:  state_d = ST_TRAIN;
            ST_TRAIN:      if (cnt_done) state_d = ST_CAPTURE;
            ST_CAPTURE:    state_d = ST_COMMIT;
            ST_COMMIT:     state_d = ST_ODT_OFF;
            ST_ODT_OFF:    if (cnt_done) state_d = ST_PREP_MS;
            ST_PREP_MS:    state_d = ST_ACK_MS;
            ST_ACK_MS:     if (prep_ack) state_d = ST_FINISH;
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // The counter is loaded with N-1 on entry, so each wait state lasts N cycles.
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        if (state_d != state_q) begin
            case (state_d)
                ST_MRS_SETTLE: begin cnt_load = 1'b1; cnt_val = CNT_W'(MRS_WAIT - 1);   end
                ST_ODT_ON:     begin cnt_load = 1'b1; cnt_val = CNT_W'(ODT_WAIT - 1);   end
                ST_TRAIN:      begin cnt_load = 1'b1; cnt_val = CNT_W'(TRAIN_WAIT - 1); end
                ST_ODT_OFF:    begin cnt_load = 1'b1; cnt_val = CNT_W'(ODT_WAIT - 1);   end
                default:       begin cnt_load = 1'b0; cnt_val = '0;                     end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            seed_q  <= '0;
            wdqs_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && start) begin
                tgt_q  <= dimm_sel_in;
                seed_q <= seed_pick_bus;
            end
            if (state_q == ST_CAPTURE) begin
                wdqs_q <= fixed_bus;
            end
        end
    end

    assign ctl         = decode_ctl(state_q);
    assign done        = ctl.done;
    assign refresh_off = ctl.refresh_off;
    assign zq_interval = ctl.refresh_off ? ZQ_OFF : ZQ_NORMAL;
    assign tgt_dimm    = tgt_q;
    assign prep_req    = ctl.prep_req;
    assign prep_level  = ctl.prep_level;
    assign odt_lvl_en  = ctl.odt;
    assign seed_wr     = ctl.seed_wr;
    assign seed_bus    = seed_q;
    assign train_en    = ctl.train;
    assign wdqs_wr     = ctl.wdqs_wr;
    assign wdqs_bus    = wdqs_q;
endmodule

// File: rtl/wlvl_seq_chk.sv
module wlvl_seq_chk #(
    parameter int BUS_W     = 64,
    parameter int TRAIN_LEN = 200
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic             refresh_off,
    input logic [1:0]       zq_interval,
    input logic             prep_req,
    input logic             prep_level,
    input logic             odt_lvl_en,
    input logic             seed_wr,
    input logic             train_en,
    input logic             wdqs_wr,
    input logic [BUS_W-1:0] wdqs_bus
);
    localparam int CW = $clog2(TRAIN_LEN + 2);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= train_en ? run_q + 1'b1 : '0;
    end

    assert_quiet_train_R2: assert property (@(posedge clk) disable iff (rst)
        train_en |-> (refresh_off && zq_interval == 2'd0));

    assert_prep_no_odt_R3: assert property (@(posedge clk) disable iff (rst)
        (prep_req && prep_level) |-> !odt_lvl_en);

    assert_seed_odt_R4: assert property (@(posedge clk) disable iff (rst)
        seed_wr |-> odt_lvl_en);

    assert_train_odt_R7: assert property (@(posedge clk) disable iff (rst)
        train_en |-> odt_lvl_en);

    assert_seed_before_train_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(train_en) |-> $past(seed_wr));

    assert_train_len_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(train_en) |-> (run_q == CW'(TRAIN_LEN)));

    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(wdqs_bus) |-> wdqs_wr);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_restore_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!refresh_off && zq_interval == 2'd2 && !odt_lvl_en));
endmodule

bind wlvl_seq wlvl_seq_chk #(.BUS_W(LANES*DW), .TRAIN_LEN(TRAIN_WAIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .refresh_off (refresh_off),
    .zq_interval (zq_interval),
    .prep_req    (prep_req),
    .prep_level  (prep_level),
    .odt_lvl_en  (odt_lvl_en),
    .seed_wr     (seed_wr),
    .train_en    (train_en),
    .wdqs_wr     (wdqs_wr),
    .wdqs_bus    (wdqs_bus)
);

// File: tb/wlvl_seq_tb_top.sv
module wlvl_seq_tb_top;
    localparam int BW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    dimm_sel_in = '0;
    logic [1:0]    dimm_kind = '0;
    logic          seed_ovr_en = 1'b0;
    logic [BW-1:0] seed_ovr = '0;
    logic          prep_ack = 1'b0;
    logic [BW-1:0] res_bus = '0;
    logic          done, refresh_off, prep_req, prep_level, odt_lvl_en;
    logic          seed_wr, train_en, wdqs_wr;
    logic [1:0]    zq_interval, tgt_dimm;
    logic [BW-1:0] seed_bus, wdqs_bus;

    int checks = 0;
    int fails  = 0;

    logic [BW-1:0] seed_exp_q[$];
    logic [BW-1:0] wdqs_exp_q[$];
    logic [BW-1:0] last_wdqs = '0;
    logic          exp_lvl = 1'b1;
    logic [1:0]    exp_dimm = '0;
    int            seed_wr_cnt = 0;
    int            done_cnt = 0;

    always #5 clk = ~clk;

    wlvl_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .dimm_sel_in(dimm_sel_in),
        .dimm_kind(dimm_kind), .seed_ovr_en(seed_ovr_en), .seed_ovr(seed_ovr),
        .prep_ack(prep_ack), .res_bus(res_bus), .done(done),
        .refresh_off(refresh_off), .zq_interval(zq_interval), .tgt_dimm(tgt_dimm),
        .prep_req(prep_req), .prep_level(prep_level), .odt_lvl_en(odt_lvl_en),
        .seed_wr(seed_wr), .seed_bus(seed_bus), .train_en(train_en),
        .wdqs_wr(wdqs_wr), .wdqs_bus(wdqs_bus)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_seed(input logic [1:0] k);
        if (k == 2'd1)      return 8'h41;
        else if (k == 2'd2) return 8'h12;
        else                return 8'h1A;
    endfunction

    function automatic logic [7:0] model_fix(input logic [7:0] s, input logic [7:0] r);
        if (s[7:5] == 3'd0 && r[7:5] == 3'd3) return 8'h00;
        return r;
    endfunction

    // Monitor: windows, prep-sequencer model and scoreboard pops
    int  ack_wait = -1;
    bit  lvl_phase = 1'b0;
    bit  mrs_on = 1'b0, odtw_on = 1'b0, off_on = 1'b0;
    int  mrs_cnt = 0, odtw_cnt = 0, off_cnt = 0, train_cnt = 0;
    logic [BW-1:0] exp_v;

    always @(negedge clk) begin
        if (!rst) begin
            if (prep_ack) begin
                prep_ack = 1'b0;
                if (lvl_phase) begin mrs_on = 1'b1; mrs_cnt = 0; end
            end
            if (mrs_on) begin
                if (odt_lvl_en) begin
                    chk(mrs_cnt == 40, "R3", "settle before ODT", BW'(mrs_cnt), 40);
                    mrs_on = 1'b0; odtw_on = 1'b1; odtw_cnt = 0;
                end else mrs_cnt++;
            end
            if (odtw_on) begin
                if (seed_wr) begin
                    chk(odtw_cnt == 10, "R4", "ODT settle before seed", BW'(odtw_cnt), 10);
                    odtw_on = 1'b0;
                end else if (odt_lvl_en) odtw_cnt++;
            end
            if (off_on) begin
                if (prep_req) begin
                    chk(off_cnt == 10 && !odt_lvl_en, "R10", "ODT-off wait", BW'(off_cnt), 10);
                    off_on = 1'b0;
                end else off_cnt++;
            end
            if (prep_req) begin
                chk(prep_level == exp_lvl, "R3", "prep level", BW'(prep_level), BW'(exp_lvl));
                if (prep_level) begin
                    chk(tgt_dimm == exp_dimm, "R3", "target dimm", BW'(tgt_dimm), BW'(exp_dimm));
                    chk(refresh_off && zq_interval == 2'd0, "R2", "quiesced at prep",
                        {refresh_off, zq_interval}, 3'b100);
                end
                lvl_phase = prep_level;
                exp_lvl   = 1'b0;
                ack_wait  = 3;
            end else if (ack_wait > 0) begin
                ack_wait--;
                if (ack_wait == 0) prep_ack = 1'b1;
            end
            if (train_en) begin
                if (train_cnt == 0)
                    chk(refresh_off && zq_interval == 2'd0, "R2", "quiesced in training",
                        {refresh_off, zq_interval}, 3'b100);
                train_cnt++;
            end else if (train_cnt != 0) begin
                chk(train_cnt == 200, "R7", "train_en length", BW'(train_cnt), 200);
                train_cnt = 0;
            end
            if (seed_wr) begin
                seed_wr_cnt++;
                if (seed_exp_q.size() == 0) chk(0, "R11", "unexpected seed write", seed_bus, 0);
                else begin
                    exp_v = seed_exp_q.pop_front();
                    chk(seed_bus == exp_v, "R5/R6", "seed bus", seed_bus, exp_v);
                end
            end
            if (wdqs_wr) begin
                off_on = 1'b1; off_cnt = 0;
                if (wdqs_exp_q.size() == 0) chk(0, "R9", "unexpected wdqs write", wdqs_bus, 0);
                else begin
                    exp_v = wdqs_exp_q.pop_front();
                    last_wdqs = exp_v;
                    chk(wdqs_bus == exp_v, "R8/R9", "wdqs bus", wdqs_bus, exp_v);
                end
            end
            if (done) begin
                done_cnt++;
                chk(!refresh_off && zq_interval == 2'd2 && !odt_lvl_en, "R10", "restore at done",
                    {odt_lvl_en, refresh_off, zq_interval}, 4'b0010);
                chk(wdqs_bus == last_wdqs, "R9", "wdqs held", wdqs_bus, last_wdqs);
            end
        end
    end

    task automatic run_pass(input logic [1:0] dimm, input logic [1:0] kind, input bit oen,
                            input logic [BW-1:0] ovr, input logic [BW-1:0] res, input bit poke);
        logic [BW-1:0] es, ew;
        for (int l = 0; l < 8; l++) begin
            es[l*8 +: 8] = oen ? ovr[l*8 +: 8] : model_seed(kind);
            ew[l*8 +: 8] = model_fix(es[l*8 +: 8], res[l*8 +: 8]);
        end
        seed_exp_q.push_back(es);
        wdqs_exp_q.push_back(ew);
        @(negedge clk);
        exp_lvl = 1'b1; exp_dimm = dimm;
        dimm_sel_in = dimm; dimm_kind = kind; seed_ovr_en = oen; seed_ovr = ovr;
        res_bus = res; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11 / R5: a second start and changed inputs mid-pass must not matter
            repeat (60) @(negedge clk);
            dimm_kind = ~kind; seed_ovr_en = ~oen; dimm_sel_in = ~dimm; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!done && !train_en && !odt_lvl_en && !prep_req && !seed_wr && !wdqs_wr,
            "R1", "strobes idle", {done, train_en, odt_lvl_en, prep_req, seed_wr, wdqs_wr}, 0);
        chk(!refresh_off && zq_interval == 2'd2, "R1", "refresh/zq", {refresh_off, zq_interval}, 2);
        chk(wdqs_bus == '0, "R1", "wdqs bus", wdqs_bus, 0);

        // unbuffered, rounding on several lanes (R5, R8, R9)
        run_pass(2'd1, 2'd0, 1'b0, '0, 64'hE300_1A60_7F80_5F65, 1'b0);
        // registered: gross 2 seed, no rounding; mid-pass start ignored (R11)
        run_pass(2'd2, 2'd1, 1'b0, '0, 64'hE300_1A60_7F80_5F65, 1'b1);
        // small-outline
        run_pass(2'd0, 2'd2, 1'b0, '0, 64'h6161_7F7F_2060_8061, 1'b0);
        // kind 3 falls back to the default seed
        run_pass(2'd3, 2'd3, 1'b0, '0, 64'h6565_6565_6565_6565, 1'b0);
        // per-lane overrides with mixed gross fields (R6, R8)
        run_pass(2'd1, 2'd1, 1'b1, 64'h601F_2000_7F05_3010, 64'h6A6A_6A6A_6A6A_6A6A, 1'b1);

        repeat (20) @(negedge clk);
        chk(seed_wr_cnt == 5, "R11", "seed writes per start", BW'(seed_wr_cnt), 5);
        chk(done_cnt == 5, "R11", "done pulses per start", BW'(done_cnt), 5);
        chk(seed_exp_q.size() == 0 && wdqs_exp_q.size() == 0, "R9", "scoreboard drained",
            BW'(seed_exp_q.size() + wdqs_exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule